// File: doc/BRIEF.md
# Charger Reference Soft-Start Sequencer

This block produces the digital setpoint code for the voltage-regulation reference DAC of a battery charger. The code is an unsigned offset in 2.5 mV units above a 0.61 V floor, so the usable range is 0 to 244 (0.61 V to 1.22 V). When enable rises, the block latches the requested target. It then waits a fixed power-up delay and climbs to the target in a fixed number of equal increments, holding each level for a fixed time. Timing is counted on a 1 kHz tick strobe, not on the fast clock, so 8 ticks give 8 ms and 2 ticks give 2 ms.

Alongside the ramp, the block watches a digitised feedback sample, given in the same code units as the setpoint. It raises an over-voltage flag once the sample is more than 106 % of the active setpoint. The flag drops only when the sample falls below 103 % of that setpoint. In between, the flag keeps its value. The analog DAC, the feedback divider and the switching stage are outside this block.

Top module: `chg_softstart_seq`

## Requirements
- R1: After synchronous reset, `dac_code` is 0, `ramp_done` is 0 and `ov_flag` is 0.
- R2: After enable rises, `dac_code` stays 0 and `ramp_done` stays 0 until 8 tick pulses have been seen. The clock edge that takes in the 8th tick loads the first step.
- R3: The step size is floor(target/8). After the k-th step (k = 1..7), `dac_code` equals k × floor(target/8).
- R4: Each step level is held for exactly 2 tick pulses. After one further tick the code is unchanged, and after the second the next step loads.
- R5: The 8th step loads the exact target code, so no rounding is left. `ramp_done` rises on that same clock edge. Code and flag then hold for as long as enable stays high, whatever further ticks arrive.
- R6: With enable low, `dac_code` returns to 0 and `ramp_done` to 0 on the next clock edge. Raising enable again restarts the full power-up delay.
- R7: The target is captured on the first clock edge after enable rises. Later changes to the target input have no effect until enable is cycled.
- R8: `ov_flag` is set one clock edge after feedback×100 > dac_code×106 holds.
- R9: `ov_flag` is cleared one clock edge after feedback×100 < dac_code×103 holds. When neither comparison holds, it keeps its value (hysteresis band).
- R10: Tick pulses seen while enable is low are not counted toward the power-up delay.
- R11: Corner targets work: a target of 0 stays at 0 and completes. A target below 8 holds 0 through steps 1..7 and then jumps to the target. The maximum target 244 ends at 244, not at 8 × 30 = 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sequence enable; low forces code 0 and re-arms the sequence |
| tick | input | 1 | One-cycle 1 kHz timing strobe |
| target | input | CODE_W | Requested final setpoint code (0..244) |
| fb_code | input | FB_W | Digitised feedback sample in setpoint code units |
| dac_code | output | CODE_W | Setpoint code driven to the reference DAC |
| ramp_done | output | 1 | High from the final step until enable drops |
| ov_flag | output | 1 | Battery over-voltage flag with hysteresis |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that `en`, `target` and `fb_code` are synchronous to `clk`. They also assume the target lies within the 0..244 range, and they read the over-voltage thresholds from the code actually driven, not from the requested target. The stimulus changes inputs only on falling clock edges and issues each tick as an isolated one-cycle pulse with idle cycles between pulses. It keeps `fb_code` at 0 during ramps, so the over-voltage flag is driven on purpose only once the setpoint has settled.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_RAMP = 2'd2,
        SQ_DONE = 2'd3
    } sq_state_e;

    localparam int PCT_W = 8;

    // Scales a code by a whole-number percentage; 32-bit result is ample
    // for codes up to 16 bits and percentages up to 255.
    function automatic logic [31:0] scale_pct(input logic [15:0] v,
                                              input logic [PCT_W-1:0] pct);
        return 32'(v) * 32'(pct);
    endfunction

endpackage

// File: rtl/ssq_tick_timer.sv
module ssq_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign expire = run && tick && (cnt == limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/ssq_ramp_ctrl.sv
module ssq_ramp_ctrl
    import ssq_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int NUM_STEPS   = 8,
    parameter int DELAY_TICKS = 8,
    parameter int STEP_TICKS  = 2,
    parameter int TMR_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] target,
    input  logic              expire,
    output logic              run,
    output logic [TMR_W-1:0]  limit,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int IDX_W = $clog2(NUM_STEPS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

    sq_state_e         state;
    logic [CODE_W-1:0] tgt_q;
    logic [CODE_W-1:0] stp_q;
    logic [IDX_W-1:0]  idx_q;

    assign run   = en && ((state == SQ_WAIT) || (state == SQ_RAMP));
    assign limit = (state == SQ_WAIT) ? TMR_W'(DELAY_TICKS) : TMR_W'(STEP_TICKS);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= SQ_IDLE;
            code  <= '0;
            done  <= 1'b0;
            tgt_q <= '0;
            stp_q <= '0;
            idx_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    tgt_q <= target;
                    stp_q <= CODE_W'(target / NUM_STEPS);
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (expire) begin
                        idx_q <= IDX_W'(1);
                        if (NUM_STEPS == 1) begin
                            code  <= tgt_q;
                            done  <= 1'b1;
                            state <= SQ_DONE;
                        end else begin
                            code  <= stp_q;
                            state <= SQ_RAMP;
                        end
                    end
                end
                SQ_RAMP: begin
                    if (expire) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == LAST_IDX) begin
                            code  <= tgt_q;
                            done  <= 1'b1;
                            state <= SQ_DONE;
                        end else begin
                            code <= code + stp_q;
                        end
                    end
                end
                default: begin
                    state <= SQ_DONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ssq_ov_detect.sv
module ssq_ov_detect
    import ssq_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int FB_W      = 9,
    parameter int TRIP_PCT  = 106,
    parameter int CLEAR_PCT = 103
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [FB_W-1:0]   fb_code,
    output logic              ov
);
    logic [31:0] fb_s;
    logic [31:0] trip_s;
    logic [31:0] clr_s;
    logic        above;
    logic        below;

    assign fb_s   = scale_pct(16'(fb_code), PCT_W'(100));
    assign trip_s = scale_pct(16'(setpoint), PCT_W'(TRIP_PCT));
    assign clr_s  = scale_pct(16'(setpoint), PCT_W'(CLEAR_PCT));
    assign above  = fb_s > trip_s;
    assign below  = fb_s < clr_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov <= 1'b0;
        end else if (above) begin
            ov <= 1'b1;
        end else if (below) begin
            ov <= 1'b0;
        end
    end
endmodule

// File: rtl/chg_softstart_seq.sv
module chg_softstart_seq #(
    parameter int CODE_W      = 8,
    parameter int FB_W        = 9,
    parameter int NUM_STEPS   = 8,
    parameter int DELAY_TICKS = 8,
    parameter int STEP_TICKS  = 2,
    parameter int TRIP_PCT    = 106,
    parameter int CLEAR_PCT   = 103
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [CODE_W-1:0] target,
    input  logic [FB_W-1:0]   fb_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              ramp_done,
    output logic              ov_flag
);
    localparam int TMR_MAX = (DELAY_TICKS > STEP_TICKS) ? DELAY_TICKS : STEP_TICKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic             run;
    logic             expire;
    logic [TMR_W-1:0] limit;

    ssq_tick_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    ssq_ramp_ctrl #(
        .CODE_W      (CODE_W),
        .NUM_STEPS   (NUM_STEPS),
        .DELAY_TICKS (DELAY_TICKS),
        .STEP_TICKS  (STEP_TICKS),
        .TMR_W       (TMR_W)
    ) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .target (target),
        .expire (expire),
        .run    (run),
        .limit  (limit),
        .code   (dac_code),
        .done   (ramp_done)
    );

    ssq_ov_detect #(
        .CODE_W    (CODE_W),
        .FB_W      (FB_W),
        .TRIP_PCT  (TRIP_PCT),
        .CLEAR_PCT (CLEAR_PCT)
    ) u_ov (
        .clk      (clk),
        .rst      (rst),
        .setpoint (dac_code),
        .fb_code  (fb_code),
        .ov       (ov_flag)
    );
endmodule

// File: rtl/chg_softstart_seq_chk.sv
module chg_softstart_seq_chk #(
    parameter int CODE_W    = 8,
    parameter int FB_W      = 9,
    parameter int TRIP_PCT  = 106,
    parameter int CLEAR_PCT = 103
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [FB_W-1:0]   fb_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              ramp_done,
    input logic              ov_flag
);
    logic [31:0] fb100;
    logic [31:0] hi_lim;
    logic [31:0] lo_lim;

    assign fb100  = 32'(fb_code) * 32'd100;
    assign hi_lim = 32'(dac_code) * 32'(TRIP_PCT);
    assign lo_lim = 32'(dac_code) * 32'(CLEAR_PCT);

    // R1: reset leaves all outputs low
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && !ramp_done && !ov_flag);

    // R6: disabled sequencer returns to zero
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (dac_code == '0) && !ramp_done);

    // R3: code never falls while enabled
    assert_code_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> dac_code >= $past(dac_code));

    // R5: completion holds code and flag
    assert_done_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (ramp_done && en) |=> ramp_done && $stable(dac_code));

    // R8: trip above upper threshold
    assert_ov_trip_R8: assert property (@(posedge clk) disable iff (rst)
        (fb100 > hi_lim) |=> ov_flag);

    // R9: release below lower threshold
    assert_ov_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (fb100 < lo_lim) && !(fb100 > hi_lim) |=> !ov_flag);

    // R9: hold inside the band
    assert_ov_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(fb100 > hi_lim) && !(fb100 < lo_lim) |=> $stable(ov_flag));
endmodule

bind chg_softstart_seq chg_softstart_seq_chk #(
    .CODE_W    (CODE_W),
    .FB_W      (FB_W),
    .TRIP_PCT  (TRIP_PCT),
    .CLEAR_PCT (CLEAR_PCT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .fb_code   (fb_code),
    .dac_code  (dac_code),
    .ramp_done (ramp_done),
    .ov_flag   (ov_flag)
);

// File: tb/chg_softstart_seq_tb.sv
module chg_softstart_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] target = 8'd0;
    logic [8:0] fb_code = 9'd0;
    logic [7:0] dac_code;
    logic       ramp_done;
    logic       ov_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chg_softstart_seq u_dut (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .target(target),
        .fb_code(fb_code), .dac_code(dac_code), .ramp_done(ramp_done),
        .ov_flag(ov_flag)
    );

    // Targets walked by the table loop (R3, R4, R5, R11 corners)
    localparam int NT = 5;
    localparam logic [7:0] TGT_TABLE [NT] = '{8'd100, 8'd244, 8'd0, 8'd7, 8'd63};

    function automatic int exp_code(int t, int k);
        if (k <= 0) return 0;
        if (k >= 8) return t;
        return k * (t / 8);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start(input logic [7:0] t);
        @(negedge clk);
        target = t;
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk(dac_code == 0 && !ramp_done, "R6 disable clears", int'(dac_code), 0);
    endtask

    task automatic full_ramp(input int t);
        start(8'(t));
        for (int i = 1; i < 8; i++) begin
            do_tick();
            chk(dac_code == 0 && !ramp_done, "R2 delay holds zero", int'(dac_code), 0);
        end
        do_tick();
        chk(int'(dac_code) == exp_code(t, 1), "R3 first step", int'(dac_code), exp_code(t, 1));
        for (int k = 2; k <= 8; k++) begin
            do_tick();
            chk(int'(dac_code) == exp_code(t, k - 1), "R4 step held", int'(dac_code), exp_code(t, k - 1));
            do_tick();
            if (k < 8)
                chk(int'(dac_code) == exp_code(t, k) && !ramp_done, "R3 step value",
                    int'(dac_code), exp_code(t, k));
            else
                chk(int'(dac_code) == t && ramp_done, "R5 exact target with done R11",
                    int'(dac_code), t);
        end
        repeat (3) do_tick();
        chk(int'(dac_code) == t && ramp_done, "R5 hold after done", int'(dac_code), t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dac_code == 0 && !ramp_done && !ov_flag, "R1 reset state", int'(dac_code), 0);
        rst = 1'b0;
        @(negedge clk);

        // Table loop over targets
        for (int i = 0; i < NT; i++) begin
            full_ramp(int'(TGT_TABLE[i]));
            stop();
        end

        // R10: ticks while disabled are not counted
        for (int i = 0; i < 5; i++) do_tick();
        start(8'd80);
        for (int i = 1; i < 8; i++) do_tick();
        chk(dac_code == 0, "R10 idle ticks ignored", int'(dac_code), 0);
        do_tick();
        chk(dac_code == 10, "R10 first step after 8 enabled ticks", int'(dac_code), 10);

        // R7: target change mid-ramp has no effect
        target = 8'd200;
        for (int i = 0; i < 14; i++) do_tick();
        chk(dac_code == 80 && ramp_done, "R7 latched target", int'(dac_code), 80);
        stop();

        // R6: drop mid-ramp, restart with full delay
        start(8'd160);
        for (int i = 0; i < 10; i++) do_tick();
        chk(dac_code == 40, "R6 mid-ramp value", int'(dac_code), 40);
        stop();
        start(8'd160);
        for (int i = 1; i < 8; i++) do_tick();
        chk(dac_code == 0, "R6 restart delay", int'(dac_code), 0);
        do_tick();
        chk(dac_code == 20, "R6 restart first step", int'(dac_code), 20);
        stop();

        // R8/R9: over-voltage hysteresis around a settled setpoint of 100
        full_ramp(100);
        @(negedge clk) fb_code = 9'd106;
        @(negedge clk);
        chk(!ov_flag, "R8 equal to trip does not set", int'(ov_flag), 0);
        fb_code = 9'd107;
        @(negedge clk);
        chk(ov_flag, "R8 above trip sets", int'(ov_flag), 1);
        fb_code = 9'd104;
        @(negedge clk);
        chk(ov_flag, "R9 band holds high", int'(ov_flag), 1);
        fb_code = 9'd103;
        @(negedge clk);
        chk(ov_flag, "R9 equal to release holds", int'(ov_flag), 1);
        fb_code = 9'd102;
        @(negedge clk);
        chk(!ov_flag, "R9 below release clears", int'(ov_flag), 0);
        fb_code = 9'd105;
        @(negedge clk);
        chk(!ov_flag, "R9 band holds low", int'(ov_flag), 0);
        fb_code = 9'd0;
        @(negedge clk);
        stop();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule